// File: doc/BRIEF.md
# Processor Status Word and Interrupt Acceptance

This block holds the status word of a processor core and decides, every cycle, whether a pending maskable hardware interrupt may be taken. A request carries a 3-bit level. It is accepted only when the global enable bit is set and the level is strictly greater than the mask level held in the status word. A mask level of 7 therefore blocks every request. On acceptance the block raises a one-cycle accept pulse. In the same update it clears the global enable bit and selects the interrupt stack.

Software interrupts arrive as a strobe with an 8-bit number. They are not gated by the enable bit or the mask. Numbers in the lower half force the interrupt stack. Numbers in the upper half leave the stack selection unchanged. A software strobe that meets an accepted hardware interrupt in the same cycle is held and executed one cycle later.

The status word can be written through a register port. It also stores an integer overflow flag and two floating-point flags, underflow and overflow. All three are loaded from external update strobes. The block exposes the whole word and each field as its own output, including the selected stack and the active register bank. Vector fetch, context saving and the arithmetic itself belong to neighbouring blocks.

Top module: `psw_irq_ctrl`

## Requirements
- R1: After reset the status word reads 0, which means interrupts disabled, interrupt stack selected, bank 0 and mask level 0. Neither accept pulse is high.
- R2: Status word layout: bit 0 overflow flag, bit 1 global enable, bit 2 stack select (1 = user stack), bit 3 bank select, bit 4 floating-point underflow, bit 5 floating-point overflow, bits 8:6 mask level. Bits 15:9 always read 0 and ignore writes. A write with wr_en replaces bits 8:0 at the next clock edge.
- R3: A hardware request with hw_req_vld is accepted only if the global enable bit is 1 and hw_req_lvl is strictly greater than the mask level. hw_accept is high for exactly the one cycle after the edge at which the request was sampled.
- R4: When the mask level is 7, no hardware request is accepted, whatever its level.
- R5: At the edge that accepts a hardware interrupt, the global enable bit and the stack-select bit both become 0.
- R6: A software strobe executes regardless of the enable bit and the mask. sw_accept pulses for one cycle after it, with its number on sw_accept_num. Numbers 0 to 127 clear the stack-select bit. Numbers 128 to 255 leave that bit unchanged.
- R7: If a software strobe arrives at the same edge as an accepted hardware interrupt, the hardware interrupt is taken first and the software interrupt executes at the next edge. A further software strobe at that next edge is dropped.
- R8: On alu_upd the overflow flag loads alu_ovf. On fp_upd the floating-point underflow flag loads fp_unf OR fp_subn, and the floating-point overflow flag loads fp_ovf OR fp_subn.
- R9: When a register write meets other updates at the same edge, the interrupt-entry clears of the enable and stack bits win over the written values. The flag update strobes also win over the write on their own bits.
- R10: int_en, int_mask, stk_user, bank_sel, ovf_flag, fpu_flag and fpo_flag always equal their fields in psw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req_vld | input | 1 | Maskable hardware request present |
| hw_req_lvl | input | 3 | Level of the hardware request |
| sw_int_vld | input | 1 | Software interrupt strobe |
| sw_int_num | input | 8 | Software interrupt number |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 16 | Status word write value |
| alu_upd | input | 1 | Integer overflow flag update strobe |
| alu_ovf | input | 1 | Integer overflow result |
| fp_upd | input | 1 | Floating-point flag update strobe |
| fp_unf | input | 1 | Floating-point underflow result |
| fp_ovf | input | 1 | Floating-point overflow result |
| fp_subn | input | 1 | Subnormal operand seen |
| psw | output | 16 | Whole status word |
| int_en | output | 1 | Global enable bit |
| int_mask | output | 3 | Mask level |
| stk_user | output | 1 | 1 = user stack, 0 = interrupt stack |
| bank_sel | output | 1 | Active register bank |
| ovf_flag | output | 1 | Integer overflow flag |
| fpu_flag | output | 1 | Floating-point underflow flag |
| fpo_flag | output | 1 | Floating-point overflow flag |
| hw_accept | output | 1 | One-cycle hardware accept pulse |
| sw_accept | output | 1 | One-cycle software execute pulse |
| sw_accept_num | output | 8 | Number of the executed software interrupt |

## Verification
Every status bit is visible on psw, so a wrong stored bit shows on the port one cycle after the edge that corrupted it. A wrong accept decision shows as a missing or extra hw_accept pulse in the very next cycle. The enable bit then fails to clear in the same cycle, which changes whether the following requests are taken. A lost or duplicated held software request shows as a sw_accept pulse one cycle early, one cycle late or missing, and as a stack bit that is wrong from then on.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
// psw_pkg: layout of the processor status word shared by the block and its checker.
// Assumes the mask field sits above the six single-bit fields and that the remaining
// upper bits are reserved.
package psw_pkg;
    localparam int PSW_W  = 16;
    localparam int LVL_W  = 3;
    localparam int VEC_W  = 8;
    localparam int P_OVF  = 0;
    localparam int P_GIE  = 1;
    localparam int P_STK  = 2;
    localparam int P_BANK = 3;
    localparam int P_FPU  = 4;
    localparam int P_FPO  = 5;
    localparam int P_MSK  = 6;
endpackage

// File: rtl/psw_accept.sv
`timescale 1ns/1ps
// psw_accept: decides hardware acceptance and sequences software interrupts.
// Assumes the level comparison is strict and that a software request colliding
// with a hardware accept is parked for exactly one cycle (a held request replaces
// any new strobe). Accept pulses are registered.
module psw_accept #(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_req_vld,
    input  logic [LVL_W-1:0] hw_req_lvl,
    input  logic             sw_int_vld,
    input  logic [VEC_W-1:0] sw_int_num,
    input  logic             gie,
    input  logic [LVL_W-1:0] mask_lvl,
    output logic             hw_take,
    output logic             sw_go,
    output logic             sw_low,
    output logic             hw_accept,
    output logic             sw_accept,
    output logic [VEC_W-1:0] sw_accept_num
);
    logic             held_q;
    logic [VEC_W-1:0] held_num_q;
    logic             src_vld;
    logic [VEC_W-1:0] src_num;

    // Strict comparison; the all-ones mask level blocks every request.
    always_comb begin
        hw_take = hw_req_vld && gie && (hw_req_lvl > mask_lvl) && (mask_lvl != '1);
    end

    // Pick the software source: a held request outranks a new strobe.
    always_comb begin
        src_vld = held_q || sw_int_vld;
        src_num = held_q ? held_num_q : sw_int_num;
        sw_go   = src_vld && !hw_take;
        sw_low  = !src_num[VEC_W-1];
    end

    // Park a colliding software request and register the accept pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q        <= 1'b0;
            held_num_q    <= '0;
            hw_accept     <= 1'b0;
            sw_accept     <= 1'b0;
            sw_accept_num <= '0;
        end else begin
            held_q     <= src_vld && hw_take;
            held_num_q <= src_num;
            hw_accept  <= hw_take;
            sw_accept  <= sw_go;
            if (sw_go) begin
                sw_accept_num <= src_num;
            end
        end
    end
endmodule

// File: rtl/psw_state.sv
`timescale 1ns/1ps
// psw_state: stores the status word. Update order inside one edge: register write,
// then flag strobes, then interrupt-entry clears, so later sources win.
// Assumes reserved bits are never stored.
module psw_state
    import psw_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int PW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_data,
    input  logic          alu_upd,
    input  logic          alu_ovf,
    input  logic          fp_upd,
    input  logic          fp_unf,
    input  logic          fp_ovf,
    input  logic          fp_subn,
    input  logic          hw_take,
    input  logic          sw_go,
    input  logic          sw_low,
    output logic [PW-1:0] psw_q
);
    localparam int RSV_LO = P_MSK + LVL_W;
    localparam logic [PW-1:0] WR_MASK = {{(PW-RSV_LO){1'b0}}, {RSV_LO{1'b1}}};
    localparam int N_FP = 2;

    logic [N_FP-1:0] fp_raw;
    logic [N_FP-1:0] fp_val;
    logic [PW-1:0]   nxt;

    assign fp_raw = {fp_ovf, fp_unf};

    // Each floating-point flag is also set by a subnormal operand.
    for (genvar g = 0; g < N_FP; g++) begin : g_fp
        assign fp_val[g] = fp_raw[g] | fp_subn;
    end

    // Next-state merge in priority order.
    always_comb begin
        nxt = psw_q;
        if (wr_en) begin
            nxt = wr_data & WR_MASK;
        end
        if (alu_upd) begin
            nxt[P_OVF] = alu_ovf;
        end
        if (fp_upd) begin
            nxt[P_FPU] = fp_val[0];
            nxt[P_FPO] = fp_val[1];
        end
        if (hw_take) begin
            nxt[P_GIE] = 1'b0;
            nxt[P_STK] = 1'b0;
        end
        if (sw_go && sw_low) begin
            nxt[P_STK] = 1'b0;
        end
    end

    // Status word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q <= '0;
        end else begin
            psw_q <= nxt;
        end
    end
endmodule

// File: rtl/psw_irq_ctrl.sv
`timescale 1ns/1ps
// psw_irq_ctrl: processor status word with maskable interrupt acceptance and
// software interrupt sequencing. Assumes the neighbouring core performs vector
// fetch and context saving on the accept pulses.
module psw_irq_ctrl
    import psw_pkg::*;
#(
    parameter int LVL_W = psw_pkg::LVL_W,
    parameter int VEC_W = psw_pkg::VEC_W,
    parameter int PW    = psw_pkg::PSW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_req_vld,
    input  logic [LVL_W-1:0] hw_req_lvl,
    input  logic             sw_int_vld,
    input  logic [VEC_W-1:0] sw_int_num,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_data,
    input  logic             alu_upd,
    input  logic             alu_ovf,
    input  logic             fp_upd,
    input  logic             fp_unf,
    input  logic             fp_ovf,
    input  logic             fp_subn,
    output logic [PW-1:0]    psw,
    output logic             int_en,
    output logic [LVL_W-1:0] int_mask,
    output logic             stk_user,
    output logic             bank_sel,
    output logic             ovf_flag,
    output logic             fpu_flag,
    output logic             fpo_flag,
    output logic             hw_accept,
    output logic             sw_accept,
    output logic [VEC_W-1:0] sw_accept_num
);
    logic hw_take;
    logic sw_go;
    logic sw_low;

    psw_accept #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_accept (
        .clk           (clk),
        .rst_n         (rst_n),
        .hw_req_vld    (hw_req_vld),
        .hw_req_lvl    (hw_req_lvl),
        .sw_int_vld    (sw_int_vld),
        .sw_int_num    (sw_int_num),
        .gie           (psw[P_GIE]),
        .mask_lvl      (psw[P_MSK +: LVL_W]),
        .hw_take       (hw_take),
        .sw_go         (sw_go),
        .sw_low        (sw_low),
        .hw_accept     (hw_accept),
        .sw_accept     (sw_accept),
        .sw_accept_num (sw_accept_num)
    );

    psw_state #(.LVL_W(LVL_W), .PW(PW)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .alu_upd (alu_upd),
        .alu_ovf (alu_ovf),
        .fp_upd  (fp_upd),
        .fp_unf  (fp_unf),
        .fp_ovf  (fp_ovf),
        .fp_subn (fp_subn),
        .hw_take (hw_take),
        .sw_go   (sw_go),
        .sw_low  (sw_low),
        .psw_q   (psw)
    );

    // Field views of the stored word.
    always_comb begin
        int_en   = psw[P_GIE];
        int_mask = psw[P_MSK +: LVL_W];
        stk_user = psw[P_STK];
        bank_sel = psw[P_BANK];
        ovf_flag = psw[P_OVF];
        fpu_flag = psw[P_FPU];
        fpo_flag = psw[P_FPO];
    end
endmodule

// File: rtl/psw_irq_ctrl_chk.sv
`timescale 1ns/1ps
// psw_irq_ctrl_chk: property checks on the ports of psw_irq_ctrl, attached by bind.
module psw_irq_ctrl_chk
    import psw_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8,
    parameter int PW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_req_vld,
    input logic [LVL_W-1:0] hw_req_lvl,
    input logic             fp_upd,
    input logic             fp_subn,
    input logic [PW-1:0]    psw,
    input logic             int_en,
    input logic [LVL_W-1:0] int_mask,
    input logic             stk_user,
    input logic             fpu_flag,
    input logic             fpo_flag,
    input logic             hw_accept,
    input logic             sw_accept,
    input logic [VEC_W-1:0] sw_accept_num
);
    localparam int RSV_LO = P_MSK + LVL_W;

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        psw[PW-1:RSV_LO] == '0);

    a_r3_no_take_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req_vld && !int_en) |=> !hw_accept);

    a_r3_no_take_at_or_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req_vld && (hw_req_lvl <= int_mask)) |=> !hw_accept);

    a_r4_mask7_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == '1) |=> !hw_accept);

    a_r5_entry_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hw_accept |-> (!int_en && !stk_user));

    a_r6_low_number_clears_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_accept && !sw_accept_num[VEC_W-1]) |-> !stk_user);

    a_r7_one_entry_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_accept && sw_accept));

    a_r8_subnormal_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_upd && fp_subn) |=> (fpu_flag && fpo_flag));
endmodule

bind psw_irq_ctrl psw_irq_ctrl_chk #(.LVL_W(LVL_W), .VEC_W(VEC_W), .PW(PW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_req_vld    (hw_req_vld),
    .hw_req_lvl    (hw_req_lvl),
    .fp_upd        (fp_upd),
    .fp_subn       (fp_subn),
    .psw           (psw),
    .int_en        (int_en),
    .int_mask      (int_mask),
    .stk_user      (stk_user),
    .fpu_flag      (fpu_flag),
    .fpo_flag      (fpo_flag),
    .hw_accept     (hw_accept),
    .sw_accept     (sw_accept),
    .sw_accept_num (sw_accept_num)
);

// File: tb/psw_irq_ctrl_bench.sv
`timescale 1ns/1ps
module psw_irq_ctrl_bench;
    localparam int LW = 3;
    localparam int VW = 8;
    localparam int PW = 16;
    localparam int MAX_CYC = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_req_vld = 0, sw_int_vld = 0, wr_en = 0;
    logic [LW-1:0] hw_req_lvl = '0;
    logic [VW-1:0] sw_int_num = '0;
    logic [PW-1:0] wr_data = '0;
    logic alu_upd = 0, alu_ovf = 0, fp_upd = 0, fp_unf = 0, fp_ovf = 0, fp_subn = 0;
    logic [PW-1:0] psw;
    logic int_en, stk_user, bank_sel, ovf_flag, fpu_flag, fpo_flag;
    logic [LW-1:0] int_mask;
    logic hw_accept, sw_accept;
    logic [VW-1:0] sw_accept_num;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_req = "R1";

    // Bench model state
    logic [PW-1:0] m_psw = '0;
    logic m_held = 0;
    logic [VW-1:0] m_hnum = '0;
    logic m_hw = 0, m_sw = 0;
    logic [VW-1:0] m_num = '0;

    psw_irq_ctrl u_psw_irq_ctrl (.*);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= MAX_CYC);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] next_psw(input logic [PW-1:0] p, input logic take,
                                               input logic go, input logic [VW-1:0] num);
        logic [PW-1:0] n;
        n = p;
        if (wr_en) n = wr_data & 16'h01FF;
        if (alu_upd) n[0] = alu_ovf;
        if (fp_upd) begin n[4] = fp_unf | fp_subn; n[5] = fp_ovf | fp_subn; end
        if (take) begin n[1] = 1'b0; n[2] = 1'b0; end
        if (go && !num[7]) n[2] = 1'b0;
        return n;
    endfunction

    function automatic logic accepts(input logic [PW-1:0] p);
        return hw_req_vld && p[1] && (hw_req_lvl > p[8:6]) && (p[8:6] != 3'd7);
    endfunction

    // One clock: predict from driven inputs, advance, then compare all outputs.
    task automatic tick();
        logic take, srcv, go;
        logic [VW-1:0] srcn;
        take = accepts(m_psw);
        srcv = m_held | sw_int_vld;
        srcn = m_held ? m_hnum : sw_int_num;
        go   = srcv && !take;
        @(posedge clk);
        #1;
        m_psw  = next_psw(m_psw, take, go, srcn);
        m_held = srcv && take;
        m_hnum = srcn;
        m_hw   = take;
        m_sw   = go;
        if (go) m_num = srcn;
        chk(cur_req, "psw", 32'(psw), 32'(m_psw));
        chk("R3", "hw_accept", 32'(hw_accept), 32'(m_hw));
        chk("R6", "sw_accept", 32'(sw_accept), 32'(m_sw));
        if (m_sw) chk("R6", "sw_accept_num", 32'(sw_accept_num), 32'(m_num));
        chk("R10", "fields", {21'd0, int_en, int_mask, stk_user, bank_sel, ovf_flag, fpu_flag, fpo_flag},
            {21'd0, m_psw[1], m_psw[8:6], m_psw[2], m_psw[3], m_psw[0], m_psw[4], m_psw[5]});
        @(negedge clk);
        hw_req_vld = 0; sw_int_vld = 0; wr_en = 0; alu_upd = 0; fp_upd = 0;
    endtask

    task automatic wr(input logic [PW-1:0] v);
        wr_en = 1; wr_data = v; tick();
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        cur_req = "R1";
        chk("R1", "reset psw", 32'(psw), 32'h0);
        chk("R1", "reset accepts", {30'd0, hw_accept, sw_accept}, 32'h0);
        @(negedge clk);

        // R2: reserved bits ignore writes and read 0
        cur_req = "R2";
        wr(16'hFFFF);
        chk("R2", "reserved bits", 32'(psw[15:9]), 32'h0);
        wr(16'h0000);

        // R3: strict level comparison
        cur_req = "R3";
        wr(16'h00C2);
        hw_req_vld = 1; hw_req_lvl = 3; tick();
        chk("R3", "equal level rejected", 32'(hw_accept), 32'h0);
        hw_req_vld = 1; hw_req_lvl = 4; tick();
        chk("R3", "higher level taken", 32'(hw_accept), 32'h1);
        cur_req = "R5";
        chk("R5", "enable cleared", 32'(int_en), 32'h0);

        // R4: mask 7 blocks level 7
        cur_req = "R4";
        wr(16'h01C2);
        hw_req_vld = 1; hw_req_lvl = 7; tick();
        chk("R4", "mask 7 blocks", 32'(hw_accept), 32'h0);

        // R6: software number halves
        cur_req = "R6";
        wr(16'h0004);
        sw_int_vld = 1; sw_int_num = 8'd127; tick();
        chk("R6", "num 127 clears stack", 32'(stk_user), 32'h0);
        wr(16'h0004);
        sw_int_vld = 1; sw_int_num = 8'd128; tick();
        chk("R6", "num 128 keeps stack", 32'(stk_user), 32'h1);

        // R7: collision, then a dropped strobe
        cur_req = "R7";
        wr(16'h0006);
        hw_req_vld = 1; hw_req_lvl = 1; sw_int_vld = 1; sw_int_num = 8'd200; tick();
        chk("R7", "hw first", {30'd0, hw_accept, sw_accept}, 32'h2);
        sw_int_vld = 1; sw_int_num = 8'd9; tick();
        chk("R7", "held sw executes", 32'(sw_accept_num), 32'd200);
        tick();
        chk("R7", "extra strobe dropped", 32'(sw_accept), 32'h0);

        // R9: write against entry clears and flag strobes
        cur_req = "R9";
        wr(16'h0002);
        wr_en = 1; wr_data = 16'h0006; hw_req_vld = 1; hw_req_lvl = 2;
        alu_upd = 1; alu_ovf = 1; tick();
        chk("R9", "entry beats write", 32'(psw[2:0]), 32'h1);

        // R8: floating-point flags
        cur_req = "R8";
        fp_upd = 1; fp_unf = 0; fp_ovf = 0; fp_subn = 1; tick();
        chk("R8", "subnormal sets both", {30'd0, fpu_flag, fpo_flag}, 32'h3);
        fp_upd = 1; fp_subn = 0; fp_unf = 1; tick();
        chk("R8", "underflow only", {30'd0, fpu_flag, fpo_flag}, 32'h2);

        // Random mix
        cur_req = "R9";
        for (int i = 0; i < 4000; i++) begin
            hw_req_vld = ($urandom % 2) == 0;
            hw_req_lvl = LW'($urandom);
            sw_int_vld = ($urandom % 6) == 0;
            sw_int_num = VW'($urandom);
            wr_en = ($urandom % 6) == 0;
            wr_data = PW'($urandom) | 16'h0002;
            alu_upd = ($urandom % 4) == 0; alu_ovf = 1'($urandom);
            fp_upd = ($urandom % 4) == 0;
            fp_unf = 1'($urandom); fp_ovf = 1'($urandom); fp_subn = ($urandom % 5) == 0;
            tick();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule